// File: doc/BRIEF.md
# Audio Frame-Clock Ratio Lock

This block watches a digital audio receive front end that runs from one master system clock. It counts how many system clocks fit into one period of the left/right frame clock (LRCK). It classifies that count as one of four oversampling ratios and reports whether the ratio is usable. Once a ratio is locked, it runs an internal frame counter at that ratio. On every LRCK rising edge it compares the counter with the edge to measure the phase slip.

The block also measures the serial bit clock (BCK) period in system clocks. That sets a slip tolerance of a fixed number of bit periods. A slip within the tolerance is ignored. A larger slip realigns the internal frame counter. For the following half frame, a busy flag is raised and the downstream datapath is told to output midscale (bipolar zero). The mute request is also held whenever no valid ratio is locked.

Top module: `audclk_ratio_lock`

## Requirements
- R1: While and after reset, until a ratio is confirmed, `ratio_ok_o` is 0, `resync_busy_o` is 0 and `mute_req_o` is 1.
- R2: The frame length is the number of system clocks between consecutive LRCK rising edges, after a two-flop synchronizer. The legal lengths map to codes 0=256, 1=384, 2=512 and 3=768. `ratio_ok_o` rises, and `ratio_code_o` takes the code, on the edge where two consecutive legal lengths are equal.
- R3: A frame length that is not one of the four legal values never makes `ratio_ok_o` rise.
- R4: With `hi_rate_i` high, a length of 768 is illegal. It is never confirmed, and a locked 768 ratio is dropped at the next LRCK edge. The other three ratios stay legal.
- R5: Once locked, a frame length that differs from the locked length by a quarter of that length or more clears `ratio_ok_o`. `ratio_code_o` does not change while `ratio_ok_o` stays high.
- R6: The slip is the distance, in system clocks, from the LRCK edge to the nearest internal frame start. The tolerance is 6 BCK periods, where the BCK period is the system clock count between synchronized BCK rising edges. A slip no greater than the tolerance causes no realignment and no busy.
- R7: A slip greater than the tolerance, while locked, restarts the frame counter at the LRCK edge. `resync_busy_o` is then high for exactly L/2-1 cycles, where L is the locked length, so it ends within the frame.
- R8: `mute_req_o` is 1 whenever `ratio_ok_o` is 0 or `resync_busy_o` is 1, and is 0 otherwise.
- R9: While unlocked, no resync is raised and the frame counter restarts silently on each LRCK edge. When a lock loss and an over-tolerance slip fall on the same LRCK edge, the lock loss wins, and `resync_busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Master system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_i | input | 1 | Left/right frame clock, asynchronous |
| bck_i | input | 1 | Serial bit clock, asynchronous |
| hi_rate_i | input | 1 | Double-speed sampling mode flag |
| ratio_code_o | output | 2 | Locked ratio code (0=256, 1=384, 2=512, 3=768) |
| ratio_ok_o | output | 1 | A legal ratio is confirmed and held |
| resync_busy_o | output | 1 | Frame counter realignment in progress |
| mute_req_o | output | 1 | Request the datapath to output midscale |

## Verification
Ratio qualification and phase realignment are both decided on the same synchronized LRCK edge. A single stretched frame can therefore both break the length tolerance and exceed the slip tolerance. The bench provokes this by holding LRCK for 100 system clocks at the 256 ratio. That is more than the 24-clock slip tolerance and also more than the 64-clock length tolerance. The bench expects the lock to drop with no busy cycle at all. It then contrasts this with a 40-clock hold, which must keep the lock and give exactly 127 busy cycles. A cycle-accurate behavioural model also follows both decisions on every clock.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   typedef enum logic [1:0] {
      RATIO_256 = 2'd0,
      RATIO_384 = 2'd1,
      RATIO_512 = 2'd2,
      RATIO_768 = 2'd3
   } ratio_e;

   localparam int NUM_RATIOS = 4;

   // system clocks per frame for each ratio code
   function automatic int ratio_len(input ratio_e r);
      case (r)
         RATIO_256: return 256;
         RATIO_384: return 384;
         RATIO_512: return 512;
         default:   return 768;
      endcase
   endfunction

endpackage

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o
);
   localparam int DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("aud_edge_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0] q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= q[i-1];
      end
   end

   assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/aud_span_cnt.sv
module aud_span_cnt #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mark,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = '1;

   if (W < 4) begin : g_bad_width
      $error("aud_span_cnt: W too small");
   end

   // cycles since the last mark, counting the mark cycle as 1, saturating
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt_o <= '0;
      else if (mark)       cnt_o <= W'(1);
      else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/aud_ratio_detect.sv
module aud_ratio_detect
   import audclk_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lr_rise,
   input  logic [CNT_W-1:0] frame_len,
   input  logic             hi_rate,
   output logic             ok_o,
   output ratio_e           code_o,
   output logic             hold_o
);
   logic [CNT_W-1:0] prev_q;
   logic             primed_q;
   logic             legal;
   ratio_e           cand;
   int               held_len;
   int               dev;

   // classify the measured length
   always_comb begin
      legal = 1'b0;
      cand  = RATIO_256;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (int'(frame_len) == ratio_len(ratio_e'(i))) begin
            legal = 1'b1;
            cand  = ratio_e'(i);
         end
      end
      if (hi_rate && cand == RATIO_768) legal = 1'b0;
   end

   // tolerance of a held lock: under a quarter of the held length
   always_comb begin
      held_len = ratio_len(code_o);
      dev      = int'(frame_len) - held_len;
      if (dev < 0) dev = -dev;
      hold_o   = ok_o && (dev * 4 < held_len) && !(hi_rate && code_o == RATIO_768);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         ok_o     <= 1'b0;
         code_o   <= RATIO_256;
      end else if (lr_rise) begin
         prev_q   <= frame_len;
         primed_q <= 1'b1;
         if (ok_o) begin
            ok_o <= hold_o;
         end else if (primed_q && frame_len == prev_q && legal) begin
            ok_o   <= 1'b1;
            code_o <= cand;
         end
      end
endmodule

// File: rtl/aud_frame_track.sv
module aud_frame_track
   import audclk_pkg::*;
#(
   parameter int CNT_W    = 11,
   parameter int BCK_W    = 8,
   parameter int SLIP_BCK = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lr_rise,
   input  logic             bck_rise,
   input  logic [BCK_W-1:0] bck_cnt,
   input  logic             hold,
   input  ratio_e           code,
   output logic             busy_o
);
   logic [CNT_W-1:0] fcnt_q;
   logic [BCK_W-1:0] bper_q;
   int               flen;
   int               slip;
   int               limit;
   logic             trig;

   always_comb begin
      flen  = ratio_len(code);
      slip  = (int'(fcnt_q) <= flen / 2) ? int'(fcnt_q) : flen - int'(fcnt_q);
      limit = SLIP_BCK * int'(bper_q);
      trig  = lr_rise && hold && (slip > limit);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        bper_q <= '0;
      else if (bck_rise) bper_q <= bck_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           fcnt_q <= '0;
      else if (lr_rise && (trig || !hold))  fcnt_q <= CNT_W'(1);
      else if (int'(fcnt_q) >= flen - 1)    fcnt_q <= '0;
      else                                  fcnt_q <= fcnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                       busy_o <= 1'b0;
      else if (trig)                                    busy_o <= 1'b1;
      else if (lr_rise && !hold)                        busy_o <= 1'b0;
      else if (busy_o && int'(fcnt_q) == flen / 2 - 1)  busy_o <= 1'b0;
endmodule

// File: rtl/audclk_ratio_lock.sv
module audclk_ratio_lock
   import audclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 11,
   parameter int BCK_W       = 8,
   parameter int SLIP_BCK    = 6
) (
   input  logic       clk_sys,
   input  logic       rst_n,
   input  logic       lrck_i,
   input  logic       bck_i,
   input  logic       hi_rate_i,
   output logic [1:0] ratio_code_o,
   output logic       ratio_ok_o,
   output logic       resync_busy_o,
   output logic       mute_req_o
);
   localparam int LONGEST = 768;

   if ((1 << CNT_W) <= LONGEST) begin : g_bad_cnt
      $error("audclk_ratio_lock: CNT_W cannot hold the longest frame");
   end
   if (SLIP_BCK < 1) begin : g_bad_slip
      $error("audclk_ratio_lock: SLIP_BCK must be positive");
   end

   logic             lr_rise, bck_rise, hold;
   logic [CNT_W-1:0] frame_len;
   logic [BCK_W-1:0] bck_cnt;
   ratio_e           code;

   aud_edge_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
      .clk(clk_sys), .rst_n(rst_n), .din(lrck_i), .rise_o(lr_rise));

   aud_edge_sync #(.STAGES(SYNC_STAGES)) u_bck_sync (
      .clk(clk_sys), .rst_n(rst_n), .din(bck_i), .rise_o(bck_rise));

   aud_span_cnt #(.W(CNT_W)) u_frame_cnt (
      .clk(clk_sys), .rst_n(rst_n), .mark(lr_rise), .cnt_o(frame_len));

   aud_span_cnt #(.W(BCK_W)) u_bck_cnt (
      .clk(clk_sys), .rst_n(rst_n), .mark(bck_rise), .cnt_o(bck_cnt));

   aud_ratio_detect #(.CNT_W(CNT_W)) u_detect (
      .clk(clk_sys), .rst_n(rst_n), .lr_rise(lr_rise), .frame_len(frame_len),
      .hi_rate(hi_rate_i), .ok_o(ratio_ok_o), .code_o(code), .hold_o(hold));

   aud_frame_track #(.CNT_W(CNT_W), .BCK_W(BCK_W), .SLIP_BCK(SLIP_BCK)) u_track (
      .clk(clk_sys), .rst_n(rst_n), .lr_rise(lr_rise), .bck_rise(bck_rise),
      .bck_cnt(bck_cnt), .hold(hold), .code(code), .busy_o(resync_busy_o));

   assign ratio_code_o = code;
   assign mute_req_o   = ~ratio_ok_o | resync_busy_o;
endmodule

// File: rtl/audclk_ratio_lock_chk.sv
module audclk_ratio_lock_chk #(
   parameter int FRAME_MAX = 768
) (
   input logic       clk_sys,
   input logic       rst_n,
   input logic       hi_rate_i,
   input logic [1:0] ratio_code_o,
   input logic       ratio_ok_o,
   input logic       resync_busy_o
);
   localparam int RUN_W = $clog2(FRAME_MAX) + 1;

   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk_sys or negedge rst_n)
      if (!rst_n)             busy_run <= '0;
      else if (resync_busy_o) busy_run <= busy_run + 1'b1;
      else                    busy_run <= '0;

   AST_BUSY_ONLY_LOCKED: assert property (@(posedge clk_sys) disable iff (!rst_n)
      resync_busy_o |-> ratio_ok_o); // R9

   AST_LOSS_ENDS_BUSY: assert property (@(posedge clk_sys) disable iff (!rst_n)
      $fell(ratio_ok_o) |-> !resync_busy_o); // R9

   AST_CODE_HELD: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (ratio_ok_o && $past(ratio_ok_o)) |-> $stable(ratio_code_o)); // R5

   AST_NO_FAST_768: assert property (@(posedge clk_sys) disable iff (!rst_n)
      ($rose(ratio_ok_o) && $past(hi_rate_i)) |-> (ratio_code_o != 2'd3)); // R4

   AST_BUSY_IN_FRAME: assert property (@(posedge clk_sys) disable iff (!rst_n)
      int'(busy_run) < FRAME_MAX); // R7

   AST_BUSY_FROM_LOCK: assert property (@(posedge clk_sys) disable iff (!rst_n)
      $rose(resync_busy_o) |-> $past(ratio_ok_o)); // R7
endmodule

bind audclk_ratio_lock audclk_ratio_lock_chk u_chk (
   .clk_sys(clk_sys),
   .rst_n(rst_n),
   .hi_rate_i(hi_rate_i),
   .ratio_code_o(ratio_code_o),
   .ratio_ok_o(ratio_ok_o),
   .resync_busy_o(resync_busy_o)
);

// File: tb/tb_audclk_ratio_lock.sv
`timescale 1ns/1ps
module tb_audclk_ratio_lock;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lrck = 1'b0, bck = 1'b0, hi = 1'b0;
   logic [1:0] code;
   logic ok, busy, mute;

   always #2 clk = ~clk;

   audclk_ratio_lock dut (
      .clk_sys(clk), .rst_n(rst_n), .lrck_i(lrck), .bck_i(bck), .hi_rate_i(hi),
      .ratio_code_o(code), .ratio_ok_o(ok), .resync_busy_o(busy), .mute_req_o(mute));

   int errs = 0, checks = 0;
   bit done = 0;
   string tag = "R1";

   // stimulus state
   int per = 256, bdiv = 4, lph = 0, bph = 0, stall = 0;
   // window counters
   int w_busy = 0, w_oklow = 0, w_badmute = 0;

   // behavioural reference state
   int m_l0 = 0, m_l1 = 0, m_l2 = 0, m_b0 = 0, m_b1 = 0, m_b2 = 0;
   int m_pc = 0, m_bc = 0, m_bper = 0, m_prev = 0, m_prim = 0;
   int m_ok = 0, m_code = 0, m_f = 0, m_busy = 0;
   int len_q[$] = '{256, 384, 512, 768};

   task automatic check(input bit good, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!good) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_step(input int li, input int bi, input int hv);
      int fl, lr, br, keep, trig, d, legal, cand, dv;
      int n_f, n_busy;
      lr = (m_l1 == 1 && m_l2 == 0);
      br = (m_b1 == 1 && m_b2 == 0);
      fl = len_q[m_code];
      d = (m_f <= fl / 2) ? m_f : fl - m_f;
      legal = 0; cand = 0;
      foreach (len_q[k]) if (m_pc == len_q[k]) begin legal = 1; cand = k; end
      if (hv != 0 && cand == 3) legal = 0;
      keep = 0; trig = 0;
      if (lr && m_ok) begin
         dv = m_pc > fl ? m_pc - fl : fl - m_pc;
         keep = (dv * 4 < fl) && !(hv != 0 && m_code == 3);
         trig = keep && (d > 6 * m_bper);
      end
      if (trig) n_busy = 1;
      else if (lr && !keep) n_busy = 0;
      else if (m_busy && m_f == fl / 2 - 1) n_busy = 0;
      else n_busy = m_busy;
      if (lr && (trig || !keep)) n_f = 1;
      else if (m_f >= fl - 1) n_f = 0;
      else n_f = m_f + 1;
      if (lr) begin
         if (m_ok) m_ok = keep;
         else if (m_prim && m_pc == m_prev && legal) begin m_ok = 1; m_code = cand; end
         m_prev = m_pc; m_prim = 1;
      end
      m_pc = lr ? 1 : (m_pc < 2047 ? m_pc + 1 : 2047);
      if (br) m_bper = m_bc;
      m_bc = br ? 1 : (m_bc < 255 ? m_bc + 1 : 255);
      m_f = n_f; m_busy = n_busy;
      m_l2 = m_l1; m_l1 = m_l0; m_l0 = li;
      m_b2 = m_b1; m_b1 = m_b0; m_b0 = bi;
   endtask

   // one clock: drive, advance the model, then compare after the edge
   task automatic cycle();
      if (stall > 0) stall--;
      else lph = (lph + 1) % per;
      bph = (bph + 1) % bdiv;
      lrck = (lph < per / 2);
      bck = (bph < bdiv / 2);
      model_step(lrck, bck, hi);
      @(negedge clk);
      check(ok == m_ok[0], tag, "model ratio_ok", ok, m_ok);
      check(code == m_code[1:0], tag, "model ratio_code", code, m_code);
      check(busy == m_busy[0], tag, "model resync_busy", busy, m_busy);
      check(mute == (m_ok == 0 || m_busy != 0), "R8", "model mute_req", mute,
            (m_ok == 0 || m_busy != 0));
      if (busy) w_busy++;
      if (!ok) w_oklow++;
      if (mute != (!ok || busy)) w_badmute++;
   endtask

   task automatic frames(input int n);
      repeat (n * per) cycle();
   endtask

   task automatic set_rate(input int p);
      per = p;
      bdiv = (p % 64 == 0) ? p / 64 : 4;
      lph = lph % per;
      bph = bph % bdiv;
   endtask

   task automatic clr();
      w_busy = 0; w_oklow = 0; w_badmute = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ok == 1'b0, "R1", "ratio_ok in reset", ok, 0);
      check(busy == 1'b0, "R1", "resync_busy in reset", busy, 0);
      check(mute == 1'b1, "R1", "mute_req in reset", mute, 1);
      rst_n = 1'b1;

      tag = "R2"; set_rate(256); frames(6);
      check(ok == 1'b1, "R2", "lock at 256", ok, 1);
      check(code == 2'd0, "R2", "code at 256", code, 0);

      tag = "R6"; clr(); stall = 20; frames(3);
      check(w_busy == 0, "R6", "busy cycles for slip 20", w_busy, 0);
      check(w_oklow == 0, "R6", "lock drops for slip 20", w_oklow, 0);

      tag = "R7"; clr(); stall = 40; frames(2);
      check(w_busy == 127, "R7", "busy cycles for slip 40", w_busy, 127);
      check(w_oklow == 0, "R7", "lock drops for slip 40", w_oklow, 0);
      check(w_badmute == 0, "R8", "mute mismatches during resync", w_badmute, 0);

      tag = "R9"; clr(); stall = 100; frames(2);
      check(w_busy == 0, "R9", "busy on lock loss plus slip", w_busy, 0);
      check(w_oklow > 0, "R9", "lock lost on slip 100", w_oklow, 1);
      frames(4);
      check(ok == 1'b1, "R2", "relock after slip", ok, 1);

      tag = "R5"; clr(); set_rate(384); frames(6);
      check(w_oklow > 0, "R5", "lock dropped on ratio change", w_oklow, 1);
      check(ok == 1'b1 && code == 2'd1, "R2", "lock at 384 (ok,code)", {ok, code}, 5);

      tag = "R2"; set_rate(512); frames(6);
      check(code == 2'd2 && ok, "R2", "lock at 512 (ok,code)", {ok, code}, 6);
      set_rate(768); frames(6);
      check(code == 2'd3 && ok, "R2", "lock at 768 (ok,code)", {ok, code}, 7);

      tag = "R4"; clr(); hi = 1'b1; frames(4);
      check(ok == 1'b0, "R4", "768 with high rate", ok, 0);
      check(w_busy == 0, "R9", "busy while unlocked", w_busy, 0);
      hi = 1'b0; frames(4);
      check(ok == 1'b1, "R4", "768 relock at normal rate", ok, 1);
      hi = 1'b1; set_rate(512); frames(5);
      check(ok == 1'b1 && code == 2'd2, "R4", "512 with high rate (ok,code)", {ok, code}, 6);

      tag = "R3"; hi = 1'b0; clr(); set_rate(300); frames(6);
      check(ok == 1'b0, "R3", "illegal length 300", ok, 0);
      check(mute == 1'b1, "R8", "mute while illegal", mute, 1);
      check(w_busy == 0, "R9", "busy while illegal", w_busy, 0);

      tag = "R2"; set_rate(256); frames(5);
      check(ok == 1'b1 && code == 2'd0, "R2", "final lock at 256 (ok,code)", {ok, code}, 4);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule